// File: doc/BRIEF.md
# I2C Register Access Slave

This block is an I2C target that gives an external master read and write access to a small file of byte-wide registers. Its 7-bit bus address is six fixed bits followed by one bit taken from a strap input, so two copies can sit on the same bus. SCL and SDA are sampled by the system clock through two-stage synchronisers. START and STOP are detected from SDA edges while SCL is high. SDA is driven as an open drain: the single output `sda_oe` pulls the line low when it is 1.

A write transfer carries the address byte, then a pointer byte, then any number of data bytes. The pointer byte selects the register and also sets or clears auto-increment. A read transfer returns bytes starting at the current pointer. The usual way to read is to write the pointer, issue a repeated START, and then read. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `i2c_regport`

## Requirements
- R1: After reset `sda_oe` is 0 and every register reads back as 0x00.
- R2: The slave matches the address byte {0,0,1,0,0,0,`addr_sel`} in its upper seven bits, sent MSB first. Bit 0 of that byte is the direction flag (1 = read, 0 = write). On a match the slave pulls SDA low during the ninth SCL clock.
- R3: When the address does not match, SDA stays released for the rest of the transfer, and no register or pointer changes until the next START.
- R4: In a write transfer, the first byte after the address is the pointer byte. Its bit 7 is the increment flag and its bits [3:0] give the register index. Every following byte is stored in the register the pointer selects. The slave acknowledges the pointer byte and each data byte on the ninth clock.
- R5: When the increment flag is 1, the pointer advances by one after each byte written or read, and it wraps from 15 to 0. When the flag is 0, the pointer stays fixed, so repeated writes overwrite one register and repeated reads return the same value.
- R6: In a read transfer the slave shifts out the selected register MSB first. It keeps sending further bytes while the master acknowledges them.
- R7: A master NACK after a read byte ends the transmission. SDA then stays released through any further clocks until the next START or STOP.
- R8: A repeated START restarts byte framing with a new address phase. The pointer set by an earlier write is kept.
- R9: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| addr_sel | input | 1 | Strap that supplies the least significant bit of the slave address |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench sees every bus event three system clocks after it reaches the pins: two synchroniser stages plus one edge-detect register. An ACK or a data bit therefore settles on `sda_oe` three clocks after SCL falls. The bench master holds each SCL phase for ten clocks and reads SDA five clocks after SCL rises, which is well after that point. Register effects are checked only through later read transfers, so every expected byte is compared against the bench model at the bit time in which it appears on the line. A separate monitor watches for any change of `sda_oe` while the bench drives SCL high.

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter int          NUM_REGS = 16,
  parameter logic [5:0]  ADDR_HI  = 6'b001000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_sel,
  output logic sda_oe
);
  localparam int PTR_W = $clog2(NUM_REGS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WDAT, S_RDAT} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  st_t              st;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [PTR_W-1:0] ptr;
  logic             incr, rd;
  logic [7:0]       regs [NUM_REGS];

  logic       addr_hit;
  logic [7:0] rd_byte;
  assign addr_hit = shreg[7:1] == {ADDR_HI, addr_sel};
  assign rd_byte  = regs[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      incr   <= 1'b0;
      rd     <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (start_det) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (st != S_RDAT) shreg <= {shreg[6:0], sda_s};
        end else if (bitcnt == 4'd9 && st == S_RDAT && sda_s) begin
          st <= S_IDLE;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          case (st)
            S_ADDR:
              if (addr_hit) begin
                sda_oe <= 1'b1;
                rd     <= shreg[0];
              end else begin
                st <= S_IDLE;
              end
            S_PTR: begin
              sda_oe <= 1'b1;
              ptr    <= shreg[PTR_W-1:0];
              incr   <= shreg[7];
            end
            S_WDAT: begin
              sda_oe     <= 1'b1;
              regs[ptr]  <= shreg;
              if (incr) ptr <= ptr + 1'b1;
            end
            S_RDAT: begin
              sda_oe <= 1'b0;
              if (incr) ptr <= ptr + 1'b1;
            end
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          case (st)
            S_ADDR:  st <= rd ? S_RDAT : S_PTR;
            S_PTR:   st <= S_WDAT;
            default: ;
          endcase
          if ((st == S_ADDR && rd) || st == S_RDAT) begin
            shreg  <= rd_byte;
            sda_oe <= ~rd_byte[7];
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (st == S_RDAT && bitcnt != 4'd0) begin
          shreg  <= {shreg[6:0], 1'b0};
          sda_oe <= ~shreg[6];
        end
      end
    end

  // R9
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  // R8
  restart_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> (st == S_ADDR && bitcnt == 4'd0));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != S_PTR && ptr != $past(ptr)) |-> ($past(incr) && ptr == $past(ptr) + 1'b1));

  // R4
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && st != S_RDAT) |-> bitcnt == 4'd9);
endmodule

// File: tb/i2c_regport_test.sv
module i2c_regport_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, sel = 1'b0;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_regport uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(sel), .sda_oe(sda_oe)
  );

  int checks = 0, fails = 0, viol = 0;
  bit done = 0;
  logic [7:0] mdl [16];
  logic [3:0] mp;
  logic       minc;
  logic [7:0] wbuf [8];
  logic       oe_prev = 1'b0;

  function automatic logic [7:0] addr_byte(input logic s, input logic r);
    return {6'b001000, s, r};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1; scl_m = 1; wt(Q);
    sda_m = 0; wt(Q);
    scl_m = 0; wt(Q);
  endtask

  task automatic bus_rstart;
    sda_m = 1; wt(Q);
    scl_m = 1; wt(Q);
    sda_m = 0; wt(Q);
    scl_m = 0; wt(Q);
  endtask

  task automatic bus_stop;
    sda_m = 0; wt(Q);
    scl_m = 1; wt(Q);
    sda_m = 1; wt(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wt(Q);
    scl_m = 1; wt(Q);
    scl_m = 0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1; wt(Q);
    scl_m = 1; wt(Q / 2);
    b = sda_line; wt(Q - Q / 2);
    scl_m = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~mack);
  endtask

  task automatic set_ptr(input logic [7:0] pb);
    logic ack;
    bus_start;
    send_byte(addr_byte(sel, 1'b0), ack);
    check("R2 write address ack", {7'd0, ack}, 8'd1);
    send_byte(pb, ack);
    check("R4 pointer ack", {7'd0, ack}, 8'd1);
    mp = pb[3:0];
    minc = pb[7];
  endtask

  task automatic do_write(input logic [7:0] pb, input int n);
    logic ack;
    set_ptr(pb);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      check("R4 data ack", {7'd0, ack}, 8'd1);
      mdl[mp] = wbuf[i];
      if (minc) mp = mp + 4'd1;
    end
    bus_stop;
  endtask

  task automatic do_read(input logic [7:0] pb, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    set_ptr(pb);
    bus_rstart;
    send_byte(addr_byte(sel, 1'b1), ack);
    check("R8 read address ack after repeated start", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      check(tag, d, mdl[mp]);
      if (minc) mp = mp + 4'd1;
    end
    bus_stop;
  endtask

  // R9 monitor: sda_oe must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && scl_m && sda_oe !== oe_prev) viol++;
    oe_prev = sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    wt(4);
    check("R1 sda released in reset", {7'd0, sda_oe}, 8'd0);
    rst_n = 1;
    wt(4);
    check("R1 sda released after reset", {7'd0, sda_oe}, 8'd0);

    // R1 / R6: all registers read zero, block read with increment
    do_read(8'h80, 16, "R1 reset contents");

    // R4 / R5 / R8: block write with increment then read back
    wbuf[0] = 8'h3C; wbuf[1] = 8'hA5; wbuf[2] = 8'h81;
    do_write(8'h82, 3);
    do_read(8'h82, 3, "R6 block read back");

    // R5: increment clear, one register overwritten, reads repeat
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    do_write(8'h05, 3);
    do_read(8'h05, 3, "R5 fixed pointer read");
    do_read(8'h86, 2, "R5 neighbours untouched");

    // R5: wrap from 15 to 0
    wbuf[0] = 8'h5F; wbuf[1] = 8'h60;
    do_write(8'h8F, 2);
    do_read(8'h8F, 2, "R5 wrap read");

    // R3: wrong address ignored
    bus_start;
    send_byte(addr_byte(~sel, 1'b0), ack);
    check("R3 no ack on mismatch", {7'd0, ack}, 8'd0);
    send_byte(8'h80, ack);
    check("R3 no ack pointer after mismatch", {7'd0, ack}, 8'd0);
    send_byte(8'hEE, ack);
    check("R3 no ack data after mismatch", {7'd0, ack}, 8'd0);
    bus_stop;
    do_read(8'h80, 1, "R3 register 0 unchanged");

    // R2: strap changes the address
    sel = 1'b1;
    wt(4);
    wbuf[0] = 8'h77;
    do_write(8'h8A, 1);
    do_read(8'h8A, 1, "R2 strap high access");
    sel = 1'b0;
    wt(4);

    // R7: NACK ends transmission, line stays released
    set_ptr(8'h02);
    bus_rstart;
    send_byte(addr_byte(sel, 1'b1), ack);
    check("R2 read address ack", {7'd0, ack}, 8'd1);
    recv_byte(d, 1'b0);
    check("R7 byte before nack", d, mdl[2]);
    recv_byte(d, 1'b0);
    check("R7 released after nack", d, 8'hFF);
    bus_stop;

    // random transfers
    for (int t = 0; t < 12; t++) begin
      logic [3:0] p;
      logic inc;
      int n;
      p = 4'($urandom % 16);
      inc = 1'($urandom % 2);
      n = 1 + int'($urandom % 4);
      sel = 1'($urandom % 2);
      wt(4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write({inc, 3'b000, p}, n);
      do_read({inc, 3'b000, p}, n, inc ? "R6 random block read" : "R5 random fixed read");
    end

    checks++;
    if (viol != 0) begin
      fails++;
      $display("FAIL R9 sda change while scl high: actual %0d expected 0", viol);
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule